// File: doc/BRIEF.md
# Self-Realigning Asynchronous Serial Receiver

This block receives asynchronous serial characters with one low start bit, eight data bits sent least significant bit first, and one high stop bit, on a line that rests high. A clock enable, `sampleTick`, divides every bit period into sixteen slices. The block registers the raw line through two flip-flops and then tracks the slice count itself. It takes each data bit at the centre of that bit's period. On each good character it gives the received byte and a strobe that lasts one clock cycle.

A receiver that joins a stream part-way through a character can lock onto a data transition by mistake and stay misaligned. To prevent this, the block refuses start edges until the line has stayed high, without a break, for eight full bit periods. It enforces this quiet interval after reset and again after every stop-bit failure. It therefore falls back into step with the real character boundaries as soon as the sender pauses for long enough.

Top module: `uart_resync_rx`

## Requirements
- R1: While reset is held and on the first cycle after it, `rxData` is 0x00 and `rxValid` and `frameErr` are low.
- R2: A character is a low start bit, then eight data bits placed into `rxData` with the first received bit at bit 0, then a stop bit. Each bit lasts 16 `sampleTick` pulses. The block reads the first data bit 24 ticks after the start edge is detected and each later bit 16 ticks after the one before it.
- R3: When the stop bit is read high, the block presents the byte on `rxData` and raises `rxValid` for exactly one clock cycle.
- R4: When the stop bit is read low, the block raises `frameErr` for one clock cycle, drops the byte, and leaves `rxData` unchanged.
- R5: After reset, the block ignores every falling edge until it has counted 128 consecutive ticks (eight bit periods) with the line high. A low sample restarts that count.
- R6: After a framing error, the block applies the same 128-tick quiet-line rule before it accepts another start bit.
- R7: If the line is high again 8 ticks after a start edge, the block discards the event without any strobe and stays ready for the next start edge.
- R8: Once the block has qualified the idle line, it receives characters sent back to back with no idle gap between them.
- R9: `rxValid` and `frameErr` are never high in the same cycle.
- R10: `rxData` changes only in a cycle where `rxValid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| serialIn | input | 1 | Raw serial line, high when idle |
| sampleTick | input | 1 | Enable pulse, 16 per bit period |
| rxData | output | 8 | Last good received byte |
| rxValid | output | 1 | One-cycle pulse when a byte is accepted |
| frameErr | output | 1 | One-cycle pulse on a low stop bit |

## Verification
The single-cycle strobe and tick-origin properties assume that `sampleTick` is high for only one clock at a time and that consecutive ticks are at least two clocks apart. The bench raises the tick on every fourth clock to meet this. The properties also assume that `serialIn` stays stable across many ticks. The stimulus therefore holds each bit for 64 clocks and changes the line only on falling clock edges. The glitch test is the one exception: it holds the line low for three ticks, well under the half-bit check point.

// File: rtl/rx_resync_pkg.sv
package rx_resync_pkg;
  typedef enum logic [2:0] {
    ST_HUNT,
    ST_ARMED,
    ST_START,
    ST_DATA,
    ST_STOP
  } rxState_t;

  typedef struct packed {
    logic shiftBit;
    logic acceptByte;
    logic flagError;
  } ctrlStrobes_t;
endpackage

// File: rtl/rx_resync_datapath.sv
module rx_resync_datapath #(
  parameter int DATA_BITS = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic serialIn,
  input  rx_resync_pkg::ctrlStrobes_t strobes,
  output logic lineSync,
  output logic [DATA_BITS-1:0] rxData,
  output logic rxValid,
  output logic frameErr
);
  logic [SYNC_STAGES-1:0] syncChain;
  logic [DATA_BITS-1:0] shiftReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncChain <= '1;
    end else begin
      syncChain <= {syncChain[SYNC_STAGES-2:0], serialIn};
    end
  end

  assign lineSync = syncChain[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      rxData   <= '0;
      rxValid  <= 1'b0;
      frameErr <= 1'b0;
    end else begin
      if (strobes.shiftBit) shiftReg <= {lineSync, shiftReg[DATA_BITS-1:1]};
      if (strobes.acceptByte) rxData <= shiftReg;
      rxValid  <= strobes.acceptByte;
      frameErr <= strobes.flagError;
    end
  end
endmodule

// File: rtl/rx_resync_ctrl.sv
module rx_resync_ctrl #(
  parameter int DATA_BITS = 8,
  parameter int OVERSAMPLE = 16,
  parameter int IDLE_BITS = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic lineSync,
  input  logic sampleTick,
  output rx_resync_pkg::ctrlStrobes_t strobes
);
  import rx_resync_pkg::*;

  localparam int IDLE_TICKS = IDLE_BITS * OVERSAMPLE;
  localparam int IW = $clog2(IDLE_TICKS);
  localparam int TW = $clog2(OVERSAMPLE);
  localparam int BW = $clog2(DATA_BITS);
  localparam logic [IW-1:0] IDLE_LAST = IW'(IDLE_TICKS - 1);
  localparam logic [TW-1:0] SLICE_LAST = TW'(OVERSAMPLE - 1);
  localparam logic [TW-1:0] HALF_LAST = TW'(OVERSAMPLE / 2 - 1);
  localparam logic [BW-1:0] BIT_LAST = BW'(DATA_BITS - 1);

  rxState_t state;
  logic [IW-1:0] idleCnt;
  logic [TW-1:0] tickCnt;
  logic [BW-1:0] bitCnt;
  logic sliceEnd;

  assign sliceEnd = sampleTick && (tickCnt == SLICE_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_HUNT;
      idleCnt <= '0;
      tickCnt <= '0;
      bitCnt  <= '0;
    end else if (sampleTick) begin
      unique case (state)
        ST_HUNT: begin
          if (!lineSync) begin
            idleCnt <= '0;
          end else if (idleCnt == IDLE_LAST) begin
            idleCnt <= '0;
            state   <= ST_ARMED;
          end else begin
            idleCnt <= idleCnt + 1'b1;
          end
        end
        ST_ARMED: begin
          if (!lineSync) begin
            tickCnt <= '0;
            state   <= ST_START;
          end
        end
        ST_START: begin
          if (tickCnt == HALF_LAST) begin
            tickCnt <= '0;
            bitCnt  <= '0;
            state   <= lineSync ? ST_ARMED : ST_DATA;
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        ST_DATA: begin
          tickCnt <= tickCnt + 1'b1;
          if (tickCnt == SLICE_LAST) begin
            if (bitCnt == BIT_LAST) state <= ST_STOP;
            else bitCnt <= bitCnt + 1'b1;
          end
        end
        ST_STOP: begin
          tickCnt <= tickCnt + 1'b1;
          if (tickCnt == SLICE_LAST) begin
            idleCnt <= '0;
            state   <= lineSync ? ST_ARMED : ST_HUNT;
          end
        end
        default: state <= ST_HUNT;
      endcase
    end
  end

  always_comb begin
    strobes.shiftBit   = (state == ST_DATA) && sliceEnd;
    strobes.acceptByte = (state == ST_STOP) && sliceEnd && lineSync;
    strobes.flagError  = (state == ST_STOP) && sliceEnd && !lineSync;
  end
endmodule

// File: rtl/uart_resync_rx.sv
module uart_resync_rx #(
  parameter int DATA_BITS = 8,
  parameter int OVERSAMPLE = 16,
  parameter int IDLE_BITS = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic serialIn,
  input  logic sampleTick,
  output logic [DATA_BITS-1:0] rxData,
  output logic rxValid,
  output logic frameErr
);
  rx_resync_pkg::ctrlStrobes_t strobes;
  logic lineSync;

  rx_resync_ctrl #(
    .DATA_BITS(DATA_BITS), .OVERSAMPLE(OVERSAMPLE), .IDLE_BITS(IDLE_BITS)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .lineSync(lineSync),
    .sampleTick(sampleTick), .strobes(strobes)
  );

  rx_resync_datapath #(.DATA_BITS(DATA_BITS), .SYNC_STAGES(2)) uPath (
    .clk(clk), .rstN(rstN), .serialIn(serialIn), .strobes(strobes),
    .lineSync(lineSync), .rxData(rxData), .rxValid(rxValid), .frameErr(frameErr)
  );
endmodule

// File: rtl/uart_resync_rx_chk.sv
module uart_resync_rx_chk #(
  parameter int DATA_BITS = 8
) (
  input logic clk,
  input logic rstN,
  input logic sampleTick,
  input logic [DATA_BITS-1:0] rxData,
  input logic rxValid,
  input logic frameErr
);
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(rxValid && frameErr)); // R9
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid); // R3
  AST_VALID_FROM_TICK: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |-> $past(sampleTick)); // R3
  AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    frameErr |=> !frameErr); // R4
  AST_ERR_FROM_TICK: assert property (@(posedge clk) disable iff (!rstN)
    frameErr |-> $past(sampleTick)); // R4
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !rxValid |-> rxData == $past(rxData)); // R10
endmodule

bind uart_resync_rx uart_resync_rx_chk #(.DATA_BITS(DATA_BITS)) uChk (
  .clk(clk), .rstN(rstN), .sampleTick(sampleTick),
  .rxData(rxData), .rxValid(rxValid), .frameErr(frameErr)
);

// File: tb/sim_uart_resync_rx.sv
module sim_uart_resync_rx;
  localparam int BIT_CLKS = 64;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serialIn = 1'b1;
  logic sampleTick = 1'b0;
  logic [7:0] rxData;
  logic rxValid, frameErr;
  logic [1:0] divCnt = '0;
  int vecCount = 0;
  int missCount = 0;
  bit done = 1'b0;
  logic [8:0] expQ[$];

  always #10 clk = ~clk;

  always @(posedge clk) begin
    divCnt <= divCnt + 2'd1;
    sampleTick <= (divCnt == 2'd3);
  end

  uart_resync_rx u0 (
    .clk(clk), .rstN(rstN), .serialIn(serialIn), .sampleTick(sampleTick),
    .rxData(rxData), .rxValid(rxValid), .frameErr(frameErr)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    vecCount++;
    if (!ok) begin
      missCount++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic idleBits(input int n);
    serialIn = 1'b1;
    repeat (n * BIT_CLKS) @(negedge clk);
  endtask

  task automatic sendFrame(input logic [7:0] b, input logic stopLvl, input bit expect_);
    if (expect_) expQ.push_back({~stopLvl, b});
    serialIn = 1'b0;
    repeat (BIT_CLKS) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      serialIn = b[i];
      repeat (BIT_CLKS) @(negedge clk);
    end
    serialIn = stopLvl;
    repeat (BIT_CLKS) @(negedge clk);
    serialIn = 1'b1;
  endtask

  // Monitor: pop expectation on every strobe
  always @(negedge clk) begin
    if (rstN && (rxValid || frameErr)) begin
      logic [8:0] e;
      check(!(rxValid && frameErr), "R9", "both strobes high", {rxValid, frameErr}, 2);
      if (expQ.size() == 0) begin
        check(1'b0, "R5/R6/R7", "unexpected strobe (valid,err,data)",
              {rxValid, frameErr, rxData}, 0);
      end else begin
        e = expQ.pop_front();
        if (e[8]) check(frameErr, "R4", "expected framing error", {rxValid, frameErr}, 1);
        else check(rxValid && rxData == e[7:0], "R2/R3/R8", "received byte",
                   {rxValid, rxData}, {1'b1, e[7:0]});
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      check(1'b0, "ALL", "watchdog expired", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(rxData == 8'h00, "R1", "rxData in reset", rxData, 0);
    check(!rxValid && !frameErr, "R1", "strobes in reset", {rxValid, frameErr}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(rxData == 8'h00 && !rxValid && !frameErr, "R1", "after reset",
          {rxValid, frameErr, rxData}, 0);

    // R5: frames before a qualified idle interval are ignored
    idleBits(2);
    sendFrame(8'h3C, 1'b1, 1'b0);
    idleBits(3);
    sendFrame(8'hA5, 1'b1, 1'b0);
    idleBits(10);
    sendFrame(8'h81, 1'b1, 1'b1);

    // R8: back-to-back frames, R2 bit ordering
    sendFrame(8'h00, 1'b1, 1'b1);
    sendFrame(8'hFF, 1'b1, 1'b1);
    sendFrame(8'hA5, 1'b1, 1'b1);
    sendFrame(8'h5A, 1'b1, 1'b1);

    // R4 framing error then R6 hunt: next frame after short gap ignored
    sendFrame(8'h37, 1'b0, 1'b1);
    idleBits(2);
    check(rxData == 8'h5A, "R4/R10", "rxData after framing error", rxData, 8'h5A);
    sendFrame(8'h42, 1'b1, 1'b0);
    idleBits(9);
    sendFrame(8'h99, 1'b1, 1'b1);

    // R7: short low glitch is dropped without error and without re-hunting
    idleBits(1);
    serialIn = 1'b0;
    repeat (12) @(negedge clk);
    serialIn = 1'b1;
    repeat (BIT_CLKS) @(negedge clk);
    check(rxData == 8'h99, "R7/R10", "rxData after glitch", rxData, 8'h99);
    sendFrame(8'h6E, 1'b1, 1'b1);

    idleBits(3);
    check(expQ.size() == 0, "R3/R8", "pending expected items", expQ.size(), 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
    $finish;
  end
endmodule